// File: doc/BRIEF.md
# Source-Routed Port-Select Switch Input Stage

This block sits at one input of a packet switch whose routes are fixed by the sender. The head flit of every packet carries a route field that lists an output-port choice for each hop still ahead. The switch does no route computation. It takes the lowest entry of that field as its own choice and shifts the field down by one entry. The next switch then finds its own choice in the same lowest position. It sends the rewritten head, and every flit after it up to and including the tail, to that one output.

Steering is combinational. The head flit reaches its output in the same cycle that it is presented. A small state register keeps the chosen port from the head until the tail is accepted. Every flit, head included, is offered on a data bus shared by all outputs, and only the chosen output sees valid. Ready from that output alone is returned to the sender, so flow control comes straight from the selected output and no flit is ever dropped or duplicated.

Top module: `sr_port_switch`

## Requirements
- R1: After reset, and during it, no output is valid, and the next accepted flit is treated as a head flit even if a packet was cut off by the reset.
- R2: For a head flit, the output port is the value in bits [1:0] of the flit (2-bit selects, 4 outputs).
- R3: For a head flit, bits [15:0] (the route field, up to 8 selects) are sent shifted right by 2 with bits [15:14] forced to zero, and bits [31:16] pass unchanged.
- R4: Flits after the head of a packet are sent with all bits unchanged.
- R5: The output chosen by the head is used for every later flit of the packet, up to and including the flit with the tail indication.
- R6: At most one output is valid in any cycle. An output is valid only while the input is valid, and no output is valid while the input is not.
- R7: The input ready equals the ready of the chosen output. The ready inputs of the other outputs have no effect.
- R8: After a tail flit is accepted, the next flit is a head. A head flit that also carries the tail indication forms a complete one-flit packet.
- R9: The outgoing tail indication equals the incoming one for the flit being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit is valid |
| in_ready | output | 1 | Incoming flit is taken this cycle |
| in_data | input | 32 | Incoming flit |
| in_last | input | 1 | Incoming flit is the packet tail |
| out_valid | output | 4 | One valid per output port |
| out_ready | input | 4 | One ready per output port |
| out_data | output | 32 | Outgoing flit, shared by all outputs |
| out_last | output | 1 | Outgoing flit is the packet tail |

## Verification
The properties assume a well-behaved sender. Once in_valid is raised, it stays high with in_data and in_last held until in_ready is seen. Reset is applied only while the input is idle. The stimulus lowers valid only between accepted flits and never changes an offered flit before it is taken. It toggles every output ready on its own, so the selected output stalls the sender while the unselected readies flip freely. Packets of one to four flits use every port select, and route fields have their high bits set to expose the zero fill. A reset in the middle of a packet confirms that the first flit afterwards is routed as a head.

// File: rtl/sr_switch_pkg.sv
package sr_switch_pkg;
    localparam int unsigned SW_FLIT_W   = 32;
    localparam int unsigned SW_SEL_W    = 2;
    localparam int unsigned SW_MAX_HOPS = 8;

    typedef enum logic {
        PH_HEAD = 1'b0,
        PH_BODY = 1'b1
    } sw_phase_e;
endpackage

// File: rtl/sr_route_strip.sv
module sr_route_strip #(
    parameter int unsigned FLIT_W   = 32,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned MAX_HOPS = 8
) (
    input  logic [FLIT_W-1:0] head_flit,
    output logic [SEL_W-1:0]  hop_sel,
    output logic [FLIT_W-1:0] stripped_flit
);
    localparam int unsigned RT_W = SEL_W * MAX_HOPS;

    logic [RT_W-1:0] route_now;
    logic [RT_W-1:0] route_next;

    assign route_now  = head_flit[RT_W-1:0];
    assign hop_sel    = route_now[SEL_W-1:0];
    assign route_next = {{SEL_W{1'b0}}, route_now[RT_W-1:SEL_W]};

    generate
        if (FLIT_W > RT_W) begin : g_payload
            assign stripped_flit = {head_flit[FLIT_W-1:RT_W], route_next};
        end else begin : g_route_only
            assign stripped_flit = route_next;
        end
    endgenerate
endmodule

// File: rtl/sr_out_steer.sv
module sr_out_steer #(
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned NUM_OUT = 4
) (
    input  logic [SEL_W-1:0]   port_sel,
    input  logic               flit_valid,
    input  logic [NUM_OUT-1:0] port_ready,
    output logic [NUM_OUT-1:0] port_valid,
    output logic               flit_ready
);
    logic [NUM_OUT-1:0] hit;

    generate
        for (genvar p = 0; p < NUM_OUT; p++) begin : g_port
            assign hit[p]        = (port_sel == SEL_W'(p));
            assign port_valid[p] = flit_valid & hit[p];
        end
    endgenerate

    assign flit_ready = |(hit & port_ready);
endmodule

// File: rtl/sr_port_switch.sv
module sr_port_switch
    import sr_switch_pkg::*;
#(
    parameter int unsigned FLIT_W   = SW_FLIT_W,
    parameter int unsigned SEL_W    = SW_SEL_W,
    parameter int unsigned MAX_HOPS = SW_MAX_HOPS,
    localparam int unsigned NUM_OUT = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FLIT_W-1:0]  in_data,
    input  logic               in_last,
    output logic [NUM_OUT-1:0] out_valid,
    input  logic [NUM_OUT-1:0] out_ready,
    output logic [FLIT_W-1:0]  out_data,
    output logic               out_last
);
    typedef struct packed {
        sw_phase_e        phase;
        logic [SEL_W-1:0] port;
    } sw_state_t;

    sw_state_t state_d, state_q;

    logic [SEL_W-1:0]  head_sel;
    logic [FLIT_W-1:0] head_rewritten;
    logic [SEL_W-1:0]  cur_port;
    logic              steer_ready;

    sr_route_strip #(
        .FLIT_W  (FLIT_W),
        .SEL_W   (SEL_W),
        .MAX_HOPS(MAX_HOPS)
    ) u_strip (
        .head_flit    (in_data),
        .hop_sel      (head_sel),
        .stripped_flit(head_rewritten)
    );

    sr_out_steer #(
        .SEL_W  (SEL_W),
        .NUM_OUT(NUM_OUT)
    ) u_steer (
        .port_sel  (cur_port),
        .flit_valid(in_valid),
        .port_ready(out_ready),
        .port_valid(out_valid),
        .flit_ready(steer_ready)
    );

    always_comb begin
        state_d  = state_q;
        cur_port = (state_q.phase == PH_HEAD) ? head_sel : state_q.port;
        out_data = (state_q.phase == PH_HEAD) ? head_rewritten : in_data;
        out_last = in_last;
        in_ready = steer_ready;
        if (in_valid && steer_ready) begin
            state_d.port  = cur_port;
            state_d.phase = in_last ? PH_HEAD : PH_BODY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_HEAD, port: '0};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/sr_port_switch_chk.sv
module sr_port_switch_chk #(
    parameter int unsigned FLIT_W  = 32,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned NUM_OUT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [FLIT_W-1:0]  in_data,
    input logic               in_last,
    input logic [NUM_OUT-1:0] out_valid,
    input logic [NUM_OUT-1:0] out_ready,
    input logic [FLIT_W-1:0]  out_data
);
    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    assert_valid_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid == (out_valid != '0));

    assert_ready_from_chosen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_ready == ((out_valid & out_ready) != '0)));

    assert_port_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_last) |=> (in_valid |-> (out_valid == $past(out_valid))));

    assert_head_after_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=>
            (in_valid |-> (out_valid == (NUM_OUT'(1) << in_data[SEL_W-1:0]))));

    assert_body_unchanged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_last) |=> (in_valid |-> (out_data == in_data)));
endmodule

bind sr_port_switch sr_port_switch_chk #(
    .FLIT_W (FLIT_W),
    .SEL_W  (SEL_W),
    .NUM_OUT(NUM_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/sr_port_switch_bench.sv
`timescale 1ns/1ps
module sr_port_switch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [3:0]  out_valid;
    logic [3:0]  out_ready = '0;
    logic [31:0] out_data;
    logic        out_last;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    bit m_head = 1;
    int m_port = 0;
    bit accepted = 0;
    bit prev_single = 0;
    bit after_reset = 0;

    always #2.5 clk = ~clk;

    sr_port_switch u_sr_port_switch (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, compared every cycle away from the clock edge
    always @(negedge clk) begin
        int port;
        logic [3:0] exp_valid;
        logic [31:0] exp_data;
        string tag;
        if (!rst_n) begin
            check("R1", "out_valid in reset", {28'd0, out_valid}, 32'd0);
            m_head = 1;
            after_reset = 1;
            prev_single = 0;
            accepted = 0;
        end else begin
            port = m_head ? int'(in_data[1:0]) : m_port;
            exp_valid = in_valid ? (4'b1 << port) : 4'b0;
            if (!in_valid)            tag = "R6";
            else if (after_reset)     tag = "R1";
            else if (m_head && prev_single) tag = "R8";
            else if (m_head)          tag = "R2";
            else                      tag = "R5";
            check(tag, "out_valid", {28'd0, out_valid}, {28'd0, exp_valid});
            check("R7", "in_ready", {31'd0, in_ready}, {31'd0, out_ready[port]});
            if (in_valid) begin
                exp_data = m_head ? ((in_data & 32'hFFFF_0000) | ((in_data & 32'h0000_FFFF) >> 2)) : in_data;
                check(m_head ? "R3" : "R4", "out_data", out_data, exp_data);
                check("R9", "out_last", {31'd0, out_last}, {31'd0, in_last});
            end
            accepted = in_valid && out_ready[port];
            if (accepted) begin
                prev_single = m_head && in_last;
                m_port = port;
                m_head = in_last;
                after_reset = 0;
            end
        end
    end

    task automatic send_flit(input logic [31:0] d, input bit last, input int ready_bias);
        in_valid = 1; in_data = d; in_last = last;
        forever begin
            @(posedge clk); #1;
            out_ready = 4'($urandom_range(0, 15));
            if (ready_bias != 0) out_ready = 4'hF;
            if (accepted) break;
        end
        in_valid = 0;
        if ($urandom_range(0, 3) == 0) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic send_packet(input logic [15:0] route, input int len, input int bias);
        for (int i = 0; i < len; i++) begin
            logic [31:0] d;
            d = (i == 0) ? {16'($urandom), route} : 32'($urandom);
            send_flit(d, i == len - 1, bias);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // every select, high route bits set to expose the zero fill
        for (int p = 0; p < 4; p++) send_packet(16'hC000 | 16'(p) | 16'h0124, 3, 0);
        send_packet(16'hFFFF, 4, 0);
        send_packet(16'h0002, 1, 0);
        send_packet(16'h0001, 1, 1);
        send_packet(16'h7FFD, 2, 0);
        for (int k = 0; k < 40; k++) send_packet(16'($urandom), $urandom_range(1, 4), 0);
        // reset in the middle of a packet
        send_flit(32'hABCD_0003, 0, 1);
        send_flit(32'h1111_2222, 0, 1);
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        send_packet(16'h0006, 2, 0);
        send_packet(16'h0009, 3, 0);
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual running expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule